// File: doc/BRIEF.md
# Channelized Frequency Command Register Bank

This block keeps the settings of a channelized frequency source: the lower band edge, the upper band edge, the channel spacing, the external reference frequency and the selected channel number. A separate serial front end decodes bus traffic into commands. Each command holds a 4-bit function code, a 4-bit scale exponent and a 24-bit value. The bank loads the one register that the function code picks and leaves the other four untouched.

From the stored values the block forms the operating frequency word as lower edge plus channel times spacing. It flags that word as out of band when it lies above the upper edge. It also reports how many channels fit in the band. A sequential divider computes that count again after any band register changes, and a busy output covers the time it takes. Every register comes out of reset holding a preset value, so the block can run with no commands loaded.

Top module: `freq_cmd_bank`

## Requirements
- R1: After reset the lower edge, upper edge, spacing, reference and channel outputs hold their preset values (defaults 2,000,000,000 / 2,250,000,000 / 1,000,000 / 10,000,000 / 0). The frequency word equals the preset lower edge, and freqValid is high.
- R2: A command with cmdValid high and cmdFunc 0 (lower edge), 1 (upper edge), 2 (spacing), 3 (reference) or 4 (channel) loads that register at the next clock edge. The loaded value is cmdValue shifted left by 3 × cmdMult bits, and bits above bit 47 are dropped.
- R3: A command changes only the register that its function code selects. All other registers keep their contents.
- R4: freqWord equals (lower edge + channel × spacing) modulo 2^48. It reflects a register write one clock edge after the edge that performs the write.
- R5: freqValid is high exactly when the exact value of lower edge + channel × spacing is at most the upper edge. It is updated on the same edge as freqWord.
- R6: A valid command whose function code is 5 to 15 changes no register. It raises cmdError for exactly the one cycle that follows its clock edge.
- R7: When countBusy is low, chanCount equals floor((upper − lower) / spacing) + 1. If the spacing is zero or the upper edge is below the lower edge, chanCount is 0.
- R8: A write to the lower edge, upper edge or spacing register drives countBusy high from the edge that performs the write until the new count is ready. Writes to the reference or channel register leave countBusy low and chanCount unchanged.
- R9: While cmdValid is low, the function, scale and value inputs have no effect on any register.
- R10: After reset, countBusy is high until the count for the preset band has been computed (251 with the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdFunc | input | 4 | Function code selecting the target register |
| cmdMult | input | 4 | Scale exponent; the value is shifted by 3 bits per unit |
| cmdValue | input | 24 | Command value field |
| startHz | output | 48 | Lower band edge register |
| stopHz | output | 48 | Upper band edge register |
| stepHz | output | 48 | Channel spacing register |
| refHz | output | 48 | Reference frequency register |
| chanNum | output | 48 | Channel number register |
| freqWord | output | 48 | Lower edge plus channel times spacing |
| freqValid | output | 1 | Frequency word lies at or below the upper edge |
| chanCount | output | 48 | Number of channels in the band |
| countBusy | output | 1 | Channel count is being recomputed |
| cmdError | output | 1 | One-cycle pulse for an unknown function code |

## Verification
The bench builds the bank with its default parameters: 48-bit registers, a 24-bit value field and a 3-bit step per scale unit. With these values the largest scale exponent pushes all but the three lowest value bits past the register top, so the truncation rule of R2 is reached. The 48-cycle division is short enough to run again after every band change. The default band gives channel counts that depend on spacing values loaded through scaled commands. It also lets the bench load a channel that lands exactly on the upper edge and then the channel one above it. Back-to-back commands check that register and frequency updates stay in step.

// File: rtl/freq_cmd_pkg.sv
package freq_cmd_pkg;

  // register slots, indexed by function code
  localparam int NUM_REGS  = 5;
  localparam int IDX_START = 0;
  localparam int IDX_STOP  = 1;
  localparam int IDX_STEP  = 2;
  localparam int IDX_REF   = 3;
  localparam int IDX_CHAN  = 4;

  // control to datapath strobes
  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;   // one-hot register write enable
    logic                divKick; // restart the channel count
  } bankStrobe_t;

endpackage

// File: rtl/fcb_ctrl.sv
module fcb_ctrl
  import freq_cmd_pkg::*;
#(
  parameter int FN_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [FN_W-1:0] cmdFunc,
  output bankStrobe_t     strb,
  output logic            cmdError
);

  logic [NUM_REGS-1:0] wrSel;
  logic                kickReg;
  logic                badCode;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gen_sel
    assign wrSel[g] = cmdValid && (cmdFunc == FN_W'(g));
  end

  assign badCode = cmdValid && (cmdFunc >= FN_W'(NUM_REGS));

  // Band writes schedule a recount on the following cycle. Reset schedules one too.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      kickReg  <= 1'b1;
      cmdError <= 1'b0;
    end else begin
      kickReg  <= wrSel[IDX_START] | wrSel[IDX_STOP] | wrSel[IDX_STEP];
      cmdError <= badCode;
    end
  end

  always_comb begin
    strb.wrSel   = wrSel;
    strb.divKick = kickReg;
  end

  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> $past(cmdValid && (cmdFunc >= FN_W'(NUM_REGS)))) else $error("error pulse without bad code"); // R6

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrSel)) else $error("more than one register selected"); // R3

endmodule

// File: rtl/fcb_divider.sv
module fcb_divider #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         kick,
  input  logic         zeroOut,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic [W-1:0] result
);

  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

  logic [W:0]       remReg;
  logic [W-1:0]     quoReg;
  logic [W-1:0]     divReg;
  logic [CNT_W-1:0] stepCnt;

  logic [W:0]   remShift;
  logic         fits;
  logic [W:0]   remNext;
  logic [W-1:0] quoNext;

  // one restoring step per clock
  always_comb begin
    remShift = {remReg[W-1:0], quoReg[W-1]};
    fits     = remShift >= {1'b0, divReg};
    remNext  = fits ? (remShift - {1'b0, divReg}) : remShift;
    quoNext  = {quoReg[W-2:0], fits};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg  <= '0;
      quoReg  <= '0;
      divReg  <= '0;
      stepCnt <= '0;
      busy    <= 1'b0;
      result  <= '0;
    end else if (kick) begin
      remReg  <= '0;
      quoReg  <= dividend;
      divReg  <= divisor;
      stepCnt <= '0;
      busy    <= !zeroOut;
      if (zeroOut) result <= '0;
    end else if (busy) begin
      remReg  <= remNext;
      quoReg  <= quoNext;
      stepCnt <= stepCnt + 1'b1;
      if (stepCnt == CNT_W'(W-1)) begin
        busy   <= 1'b0;
        result <= quoNext + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fcb_datapath.sv
module fcb_datapath
  import freq_cmd_pkg::*;
#(
  parameter int VAL_W      = 24,
  parameter int MUL_W      = 4,
  parameter int REG_W      = 48,
  parameter int SHIFT_UNIT = 3,
  parameter logic [REG_W-1:0] PRESET_START = REG_W'(64'd2000000000),
  parameter logic [REG_W-1:0] PRESET_STOP  = REG_W'(64'd2250000000),
  parameter logic [REG_W-1:0] PRESET_STEP  = REG_W'(64'd1000000),
  parameter logic [REG_W-1:0] PRESET_REF   = REG_W'(64'd10000000),
  parameter logic [REG_W-1:0] PRESET_CHAN  = REG_W'(64'd0)
) (
  input  logic             clk,
  input  logic             rstN,
  input  bankStrobe_t      strb,
  input  logic [MUL_W-1:0] cmdMult,
  input  logic [VAL_W-1:0] cmdValue,
  output logic [REG_W-1:0] startHz,
  output logic [REG_W-1:0] stopHz,
  output logic [REG_W-1:0] stepHz,
  output logic [REG_W-1:0] refHz,
  output logic [REG_W-1:0] chanNum,
  output logic [REG_W-1:0] freqWord,
  output logic             freqValid,
  output logic [REG_W-1:0] chanCount,
  output logic             countBusy
);

  localparam int PROD_W = 2 * REG_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic [REG_W-1:0] PRESETS [NUM_REGS] =
    '{PRESET_START, PRESET_STOP, PRESET_STEP, PRESET_REF, PRESET_CHAN};
  localparam logic [SUM_W-1:0] PRESET_SUM =
    SUM_W'(PRESET_START) + SUM_W'(PROD_W'(PRESET_CHAN) * PROD_W'(PRESET_STEP));

  logic [REG_W-1:0] regFile [NUM_REGS];
  logic [REG_W-1:0] loadWord;

  // scaled command value, upper bits past the register are dropped
  always_comb begin
    loadWord = REG_W'(cmdValue) << (SHIFT_UNIT * int'(cmdMult));
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gen_reg
    always_ff @(posedge clk) begin
      if (!rstN)              regFile[g] <= PRESETS[g];
      else if (strb.wrSel[g]) regFile[g] <= loadWord;
    end
  end

  assign startHz = regFile[IDX_START];
  assign stopHz  = regFile[IDX_STOP];
  assign stepHz  = regFile[IDX_STEP];
  assign refHz   = regFile[IDX_REF];
  assign chanNum = regFile[IDX_CHAN];

  // frequency word and band check
  logic [PROD_W-1:0] chanProd;
  logic [SUM_W-1:0]  freqFull;

  always_comb begin
    chanProd = PROD_W'(chanNum) * PROD_W'(stepHz);
    freqFull = SUM_W'(startHz) + SUM_W'(chanProd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqWord  <= PRESET_SUM[REG_W-1:0];
      freqValid <= PRESET_SUM <= SUM_W'(PRESET_STOP);
    end else begin
      freqWord  <= freqFull[REG_W-1:0];
      freqValid <= freqFull <= SUM_W'(stopHz);
    end
  end

  // channel count
  logic             bandOk;
  logic             divBusy;
  logic [REG_W-1:0] bandSpan;

  assign bandOk   = (stepHz != '0) && (stopHz >= startHz);
  assign bandSpan = stopHz - startHz;

  fcb_divider #(.W(REG_W)) i_div (
    .clk      (clk),
    .rstN     (rstN),
    .kick     (strb.divKick),
    .zeroOut  (!bandOk),
    .dividend (bandSpan),
    .divisor  (stepHz),
    .busy     (divBusy),
    .result   (chanCount)
  );

  assign countBusy = divBusy | strb.divKick;

  AST_KICK_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.divKick && bandOk) |=> divBusy) else $error("divider did not start"); // R8

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!countBusy && !$past(countBusy)) |-> $stable(chanCount)) else $error("count moved while idle"); // R7

endmodule

// File: rtl/freq_cmd_bank.sv
module freq_cmd_bank
  import freq_cmd_pkg::*;
#(
  parameter int FN_W       = 4,
  parameter int VAL_W      = 24,
  parameter int MUL_W      = 4,
  parameter int REG_W      = 48,
  parameter int SHIFT_UNIT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [FN_W-1:0]  cmdFunc,
  input  logic [MUL_W-1:0] cmdMult,
  input  logic [VAL_W-1:0] cmdValue,
  output logic [REG_W-1:0] startHz,
  output logic [REG_W-1:0] stopHz,
  output logic [REG_W-1:0] stepHz,
  output logic [REG_W-1:0] refHz,
  output logic [REG_W-1:0] chanNum,
  output logic [REG_W-1:0] freqWord,
  output logic             freqValid,
  output logic [REG_W-1:0] chanCount,
  output logic             countBusy,
  output logic             cmdError
);

  bankStrobe_t strb;

  fcb_ctrl #(.FN_W(FN_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdFunc  (cmdFunc),
    .strb     (strb),
    .cmdError (cmdError)
  );

  fcb_datapath #(
    .VAL_W      (VAL_W),
    .MUL_W      (MUL_W),
    .REG_W      (REG_W),
    .SHIFT_UNIT (SHIFT_UNIT)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmdMult   (cmdMult),
    .cmdValue  (cmdValue),
    .startHz   (startHz),
    .stopHz    (stopHz),
    .stepHz    (stepHz),
    .refHz     (refHz),
    .chanNum   (chanNum),
    .freqWord  (freqWord),
    .freqValid (freqValid),
    .chanCount (chanCount),
    .countBusy (countBusy)
  );

endmodule

// File: tb/test_freq_cmd_bank.sv
`timescale 1ns/1ps
module test_freq_cmd_bank;

  localparam int W = 48;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [3:0]    cmdFunc = '0;
  logic [3:0]    cmdMult = '0;
  logic [23:0]   cmdValue = '0;
  logic [W-1:0]  startHz, stopHz, stepHz, refHz, chanNum, freqWord, chanCount;
  logic          freqValid, countBusy, cmdError;

  always #2.5 clk = ~clk;

  freq_cmd_bank i_freq_cmd_bank (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdFunc(cmdFunc),
    .cmdMult(cmdMult), .cmdValue(cmdValue), .startHz(startHz), .stopHz(stopHz),
    .stepHz(stepHz), .refHz(refHz), .chanNum(chanNum), .freqWord(freqWord),
    .freqValid(freqValid), .chanCount(chanCount), .countBusy(countBusy),
    .cmdError(cmdError)
  );

  int checks = 0;
  int fails  = 0;
  int cycleCnt = 0;
  bit done = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // reference model state
  logic [W-1:0] mReg [5] = '{W'(64'd2000000000), W'(64'd2250000000),
                             W'(64'd1000000), W'(64'd10000000), W'(64'd0)};

  typedef struct {
    int           due;
    bit           isFreq;
    logic [W-1:0] regs [5];
    bit           err;
    logic [W-1:0] freq;
    bit           valid;
    string        tag;
  } expItem_t;

  expItem_t expQ [$];

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] modelFreq();
    logic [2*W-1:0] p;
    p = (2*W)'(mReg[4]) * (2*W)'(mReg[2]);
    return mReg[0] + p[W-1:0];
  endfunction

  function automatic bit modelValid();
    logic [2*W:0] s;
    s = (2*W+1)'(mReg[0]) + (2*W+1)'((2*W)'(mReg[4]) * (2*W)'(mReg[2]));
    return s <= (2*W+1)'(mReg[1]);
  endfunction

  function automatic logic [W-1:0] modelCount();
    if (mReg[2] == '0 || mReg[1] < mReg[0]) return '0;
    return (mReg[1] - mReg[0]) / mReg[2] + 1'b1;
  endfunction

  // driver: one command per cycle, pushes the expected register and frequency items
  task automatic sendCmd(input bit v, input logic [3:0] f, input logic [3:0] m,
                         input logic [23:0] val, input string tag);
    expItem_t it;
    logic [W-1:0] lw;
    int c;
    @(negedge clk);
    cmdValid = v; cmdFunc = f; cmdMult = m; cmdValue = val;
    c = cycleCnt;
    lw = W'(val) << (3 * int'(m));
    if (v && f < 4'd5) mReg[f] = lw;
    it.due = c + 1; it.isFreq = 0; it.regs = mReg; it.err = v && (f >= 4'd5);
    it.freq = '0; it.valid = 0; it.tag = tag;
    expQ.push_back(it);
    it.due = c + 2; it.isFreq = 1; it.freq = modelFreq(); it.valid = modelValid();
    expQ.push_back(it);
    @(posedge clk);
    #1;
    cmdValid = 1'b0; cmdFunc = '0; cmdMult = '0; cmdValue = '0;
  endtask

  // monitor: compares items when their cycle comes
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due <= cycleCnt) begin
      expItem_t it;
      it = expQ.pop_front();
      if (it.isFreq) begin
        check(freqWord == it.freq, {it.tag, " R4 freqWord"}, freqWord, it.freq);
        check(freqValid == it.valid, {it.tag, " R5 freqValid"}, W'(freqValid), W'(it.valid));
      end else begin
        check(startHz == it.regs[0], {it.tag, " R3 startHz"}, startHz, it.regs[0]);
        check(stopHz  == it.regs[1], {it.tag, " R3 stopHz"},  stopHz,  it.regs[1]);
        check(stepHz  == it.regs[2], {it.tag, " R2 stepHz"},  stepHz,  it.regs[2]);
        check(refHz   == it.regs[3], {it.tag, " R2 refHz"},   refHz,   it.regs[3]);
        check(chanNum == it.regs[4], {it.tag, " R2 chanNum"}, chanNum, it.regs[4]);
        check(cmdError == it.err, {it.tag, " R6 cmdError"}, W'(cmdError), W'(it.err));
      end
    end
  end

  task automatic waitCount(input string tag);
    int guard = 0;
    @(negedge clk);
    while (countBusy && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    check(!countBusy, {tag, " R7 busy cleared"}, W'(countBusy), '0);
    check(chanCount == modelCount(), {tag, " R7 chanCount"}, chanCount, modelCount());
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] cntBefore;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // reset state (R1, R10)
    check(startHz == W'(64'd2000000000), "R1 startHz preset", startHz, W'(64'd2000000000));
    check(stopHz  == W'(64'd2250000000), "R1 stopHz preset", stopHz, W'(64'd2250000000));
    check(stepHz  == W'(64'd1000000), "R1 stepHz preset", stepHz, W'(64'd1000000));
    check(refHz   == W'(64'd10000000), "R1 refHz preset", refHz, W'(64'd10000000));
    check(chanNum == '0, "R1 chanNum preset", chanNum, '0);
    check(freqWord == W'(64'd2000000000), "R1 freqWord preset", freqWord, W'(64'd2000000000));
    check(freqValid, "R1 freqValid preset", W'(freqValid), W'(1));
    check(countBusy, "R10 busy after reset", W'(countBusy), W'(1));
    waitCount("R10 preset count");
    check(chanCount == W'(251), "R10 preset count 251", chanCount, W'(251));

    // channels: in band, on the upper edge, one past it
    sendCmd(1, 4'd4, 4'd0, 24'd5, "R2 chan5");
    sendCmd(1, 4'd4, 4'd0, 24'd250, "R5 chan edge");
    sendCmd(1, 4'd4, 4'd0, 24'd251, "R5 chan over");
    drain();

    // scaled spacing: 78125 << 3 = 625000
    sendCmd(1, 4'd2, 4'd1, 24'd78125, "R2 step scaled");
    check(countBusy, "R8 busy after step write", W'(countBusy), W'(1));
    waitCount("R8 step recount");
    // scaled upper edge: 4296875 << 9 = 2.2e9
    sendCmd(1, 4'd1, 4'd3, 24'd4296875, "R2 stop scaled");
    waitCount("R7 stop recount");

    // reference write with truncation; no recount
    cntBefore = chanCount;
    sendCmd(1, 4'd3, 4'd15, 24'hFFFFFF, "R2 ref truncated");
    check(!countBusy, "R8 ref write leaves busy low", W'(countBusy), '0);
    drain();
    check(chanCount == cntBefore, "R8 count unchanged after ref", chanCount, cntBefore);

    // unknown codes and idle inputs
    sendCmd(1, 4'd7, 4'd2, 24'd123, "R6 code7");
    sendCmd(1, 4'd15, 4'd0, 24'd9, "R6 code15");
    sendCmd(0, 4'd0, 4'd0, 24'd77, "R9 idle start");
    sendCmd(0, 4'd4, 4'd1, 24'd3, "R9 idle chan");
    drain();
    check(!countBusy, "R9 idle no recount", W'(countBusy), '0);

    // zero spacing and inverted band
    sendCmd(1, 4'd2, 4'd0, 24'd0, "R7 step zero");
    waitCount("R7 zero step count");
    sendCmd(1, 4'd2, 4'd0, 24'd500000, "R2 step restore");
    sendCmd(1, 4'd0, 4'd3, 24'd4492188, "R7 start above stop");
    waitCount("R7 inverted band count");
    sendCmd(1, 4'd0, 4'd3, 24'd3906250, "R2 start restore");
    waitCount("R7 restored count");

    // back-to-back mix
    sendCmd(1, 4'd4, 4'd0, 24'd100, "R4 b2b chan");
    sendCmd(1, 4'd2, 4'd2, 24'd15625, "R4 b2b step");
    sendCmd(1, 4'd4, 4'd0, 24'd201, "R4 b2b chan2");
    sendCmd(1, 4'd9, 4'd0, 24'd1, "R6 b2b bad");
    sendCmd(1, 4'd4, 4'd0, 24'd200, "R5 b2b edge");
    waitCount("R7 b2b count");
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule